// File: doc/BRIEF.md
# Edge-Captured Message Interrupt Concentrator

This block gathers up to eleven device interrupt request lines, synchronizes them, and looks for low-to-high transitions on the ones that software has enabled. Each qualifying transition sets a sticky pending bit. The host is alerted by a single posted write on a one-beat request port, and it never sees a dedicated interrupt wire. The host programs one target word. Its upper bits give the write address and its low five bits give the data value that identifies this source.

After a write has gone out, the block stays quiet until software collects the pending bits through one of two clearing reads. A separate live-level view lets a driver find inputs that are still asserted after the edge has been consumed, so level-sensitive behaviour can be built in software on top of edge capture. Bit 9 is not implemented. The implemented set is `IMPL_MASK` = 0x5FF.

Top module: `irq_msg_concentrator`

## Requirements
- R1: After reset the pending, enable-mask and control registers read 0 and `msg_valid` is low.
- R2: A rising edge on an implemented input whose mask bit is 1 sets that pending bit and requests one write. An input that is already high when its mask bit is set causes no write and no pending bit.
- R3: An input whose mask bit is 0 never sets a pending bit and never causes a write.
- R4: Bits outside 0x5FF (bit 9) always read 0 in the mask, pending and level registers, and input 9 never causes a write.
- R5: A read at offset 0x00C returns the pending bits on `reg_rdata[10:0]` one cycle later and clears them. An edge captured in the same cycle as that read stays pending, and it requests a new write.
- R6: A read at offset 0x01C also returns the pending bits and clears them, and it leaves the level register at 0x028 unchanged.
- R7: Offset 0x028 reads the synchronized live input levels ANDed with 0x5FF.
- R8: Offset 0x004 is the read/write target word. A delivery write carries address = target with bits [4:0] forced to 0, and data = target[4:0] zero-extended.
- R9: After a write has been requested, edges only accumulate pending bits until a clearing read at 0x00C or 0x01C. After that read, the next edge requests a new write.
- R10: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold. A later change of the target word does not alter the held write.
- R11: Control offset 0x024 bit 0 enables capture. While it is 0, edges set no pending bit and cause no write.
- R12: Edges on several enabled inputs in the same cycle merge into one pending snapshot and one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IRQ | Asynchronous device request lines |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data, registered |
| reg_rvalid | output | 1 | High the cycle after a read strobe |
| msg_valid | output | 1 | Delivery write request |
| msg_ready | input | 1 | Write port accepts the request |
| msg_addr | output | DATA_W | Delivery write address |
| msg_data | output | DATA_W | Delivery write data |

## Verification
The hardest case to reach is an input edge that reaches the capture stage in the very cycle when a clearing read is sampled. In that cycle the old snapshot must be returned, the new bit must survive, and the block must re-arm and issue a write at once. The bench counts the synchronizer and edge registers and raises the line exactly two falling clock edges before it drives the read strobe. It then checks both the returned word and the follow-up write. A second awkward case is a write stalled at the port while the target word is rewritten, which the bench creates by holding `msg_ready` low across a register write.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Register byte offsets; host software decodes these.
  localparam int OFF_TARGET   = 'h004;
  localparam int OFF_PEND_RC  = 'h00C;
  localparam int OFF_MASK     = 'h018;
  localparam int OFF_PEND_CLR = 'h01C;
  localparam int OFF_CTRL     = 'h024;
  localparam int OFF_LEVEL    = 'h028;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TARGET,
    SEL_PEND_RC,
    SEL_MASK,
    SEL_PEND_CLR,
    SEL_CTRL,
    SEL_LEVEL
  } irqc_sel_e;
endpackage

// File: rtl/irqc_edge.sv
module irqc_edge #(
  parameter int N      = 11,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] irq_in,
  output logic [N-1:0] level,
  output logic [N-1:0] rise
);
  localparam int LAST = STAGES - 1;

  logic [N-1:0] chain [STAGES];
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= irq_in;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= chain[LAST];
  end

  assign level = chain[LAST];
  assign rise  = chain[LAST] & ~prev_q;
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int           N      = 11,
  parameter logic [N-1:0] IMPL   = 11'h5FF,
  parameter int           REG_AW = 12,
  parameter int           DW     = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  input  logic [N-1:0]  level,
  input  logic [N-1:0]  rise,
  output logic [N-1:0]  qual_rise,
  output logic [N-1:0]  pend_q,
  output logic [N-1:0]  mask_q,
  output logic [DW-1:0] target_q,
  output logic          clr_rd
);
  localparam int PADW = DW - N;

  irqc_sel_e sel;
  logic      ctrl_en_q;
  logic [DW-1:0] rd_mux;

  always_comb begin
    if      (addr == REG_AW'(OFF_TARGET))   sel = SEL_TARGET;
    else if (addr == REG_AW'(OFF_PEND_RC))  sel = SEL_PEND_RC;
    else if (addr == REG_AW'(OFF_MASK))     sel = SEL_MASK;
    else if (addr == REG_AW'(OFF_PEND_CLR)) sel = SEL_PEND_CLR;
    else if (addr == REG_AW'(OFF_CTRL))     sel = SEL_CTRL;
    else if (addr == REG_AW'(OFF_LEVEL))    sel = SEL_LEVEL;
    else                                    sel = SEL_NONE;
  end

  assign clr_rd    = rd_en && (sel == SEL_PEND_RC || sel == SEL_PEND_CLR);
  assign qual_rise = rise & mask_q & IMPL & {N{ctrl_en_q}};

  always_comb begin
    unique case (sel)
      SEL_TARGET:               rd_mux = target_q;
      SEL_PEND_RC, SEL_PEND_CLR: rd_mux = {{PADW{1'b0}}, pend_q};
      SEL_MASK:                 rd_mux = {{PADW{1'b0}}, mask_q};
      SEL_CTRL:                 rd_mux = {{(DW-1){1'b0}}, ctrl_en_q};
      SEL_LEVEL:                rd_mux = {{PADW{1'b0}}, level & IMPL};
      default:                  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      target_q  <= '0;
      mask_q    <= '0;
      ctrl_en_q <= 1'b0;
      pend_q    <= '0;
      rdata     <= '0;
      rvalid    <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_mux;
      if (wr_en) begin
        case (sel)
          SEL_TARGET: target_q  <= wdata;
          SEL_MASK:   mask_q    <= wdata[N-1:0] & IMPL;
          SEL_CTRL:   ctrl_en_q <= wdata[0];
          default: ;
        endcase
      end
      pend_q <= (clr_rd ? '0 : pend_q) | qual_rise;
    end
  end
endmodule

// File: rtl/irqc_deliver.sv
module irqc_deliver #(
  parameter int DW    = 32,
  parameter int TAG_W = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          any_rise,
  input  logic          clr_rd,
  input  logic [DW-1:0] target,
  input  logic          msg_ready,
  output logic          msg_valid,
  output logic [DW-1:0] msg_addr,
  output logic [DW-1:0] msg_data
);
  localparam logic [DW-1:0] TAG_MASK = {{(DW-TAG_W){1'b0}}, {TAG_W{1'b1}}};

  logic armed_q;
  logic new_req;
  logic port_free;

  // A clearing read re-arms in the same cycle, so a coincident edge fires.
  assign new_req   = any_rise && (armed_q || clr_rd);
  assign port_free = !msg_valid || msg_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q   <= 1'b1;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      if (new_req)     armed_q <= 1'b0;
      else if (clr_rd) armed_q <= 1'b1;
      msg_valid <= (msg_valid && !msg_ready) || new_req;
      if (new_req && port_free) begin
        msg_addr <= target & ~TAG_MASK;
        msg_data <= target & TAG_MASK;
      end
    end
  end
endmodule

// File: rtl/irq_msg_concentrator.sv
module irq_msg_concentrator #(
  parameter int                 NUM_IRQ     = 11,
  parameter logic [NUM_IRQ-1:0] IMPL_MASK   = 11'h5FF,
  parameter int                 SYNC_STAGES = 2,
  parameter int                 REG_AW      = 12,
  parameter int                 DATA_W      = 32,
  parameter int                 TAG_W       = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_IRQ-1:0]  irq_in,
  input  logic                reg_wr_en,
  input  logic                reg_rd_en,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                reg_rvalid,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [DATA_W-1:0]   msg_addr,
  output logic [DATA_W-1:0]   msg_data
);
  logic [NUM_IRQ-1:0] level_w;
  logic [NUM_IRQ-1:0] rise_w;
  logic [NUM_IRQ-1:0] qual_rise_w;
  logic [NUM_IRQ-1:0] pend_w;
  logic [NUM_IRQ-1:0] mask_w;
  logic [DATA_W-1:0]  target_w;
  logic               clr_rd_w;

  irqc_edge #(.N(NUM_IRQ), .STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .irq_in(irq_in), .level(level_w), .rise(rise_w)
  );

  irqc_regs #(.N(NUM_IRQ), .IMPL(IMPL_MASK), .REG_AW(REG_AW), .DW(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr_en), .rd_en(reg_rd_en), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .rvalid(reg_rvalid),
    .level(level_w), .rise(rise_w), .qual_rise(qual_rise_w),
    .pend_q(pend_w), .mask_q(mask_w), .target_q(target_w), .clr_rd(clr_rd_w)
  );

  irqc_deliver #(.DW(DATA_W), .TAG_W(TAG_W)) u_deliver (
    .clk(clk), .rst(rst),
    .any_rise(|qual_rise_w), .clr_rd(clr_rd_w), .target(target_w),
    .msg_ready(msg_ready), .msg_valid(msg_valid),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int           N    = 11,
  parameter logic [N-1:0] IMPL = 11'h5FF,
  parameter int           DW   = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          msg_valid,
  input logic          msg_ready,
  input logic [DW-1:0] msg_addr,
  input logic [DW-1:0] msg_data,
  input logic [N-1:0]  pend_q,
  input logic [N-1:0]  mask_q,
  input logic [N-1:0]  qual_rise,
  input logic          clr_rd
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  p_hold_valid_r10: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid);

  p_hold_fields_r10: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> $stable(msg_addr) && $stable(msg_data));

  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (|qual_rise) |=> ((pend_q & $past(qual_rise)) == $past(qual_rise)));

  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    clr_rd && !(|qual_rise) |=> (pend_q == '0));

  p_masked_r3: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ((pend_q & ~$past(pend_q) & ~$past(mask_q)) == '0));

  p_unimpl_r4: assert property (@(posedge clk) disable iff (rst)
    ((pend_q | mask_q) & ~IMPL) == '0);
endmodule

bind irq_msg_concentrator irqc_checker #(.N(NUM_IRQ), .IMPL(IMPL_MASK), .DW(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data), .pend_q(pend_w), .mask_q(mask_w),
  .qual_rise(qual_rise_w), .clr_rd(clr_rd_w)
);

// File: tb/test_irq_msg_concentrator.sv
`timescale 1ns/1ps
module test_irq_msg_concentrator;
  localparam int N  = 11;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam logic [DW-1:0] TGT   = 32'hABCD_E015;
  localparam logic [DW-1:0] T_ADR = 32'hABCD_E000;
  localparam logic [DW-1:0] T_DAT = 32'h0000_0015;

  typedef struct packed {
    logic [N-1:0] mask;
    logic [N-1:0] pat;
    logic [N-1:0] exp;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{11'h7FF, 11'h001, 11'h001},
    '{11'h5FF, 11'h600, 11'h400},
    '{11'h0F0, 11'h0FF, 11'h0F0},
    '{11'h000, 11'h7FF, 11'h000},
    '{11'h200, 11'h200, 11'h000},
    '{11'h5FF, 11'h50A, 11'h50A},
    '{11'h00F, 11'h3F0, 11'h000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] irq_in = '0;
  logic reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic reg_rvalid;
  logic msg_valid;
  logic msg_ready = 1'b0;
  logic [DW-1:0] msg_addr, msg_data;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_msg_concentrator i_irq_msg_concentrator (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input int a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = AW'(a);
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic accept();
    @(negedge clk);
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] rd;
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(2);

    // R1 reset state
    check("R1 msg_valid", {31'b0, msg_valid}, 0);
    reg_read('h018, rd); check("R1 mask", rd, 0);
    reg_read('h024, rd); check("R1 ctrl", rd, 0);
    reg_read('h00C, rd); check("R1 pending", rd, 0);

    reg_write('h024, 1);
    reg_write('h004, TGT);
    reg_read('h004, rd); check("R8 target readback", rd, TGT);

    // Table walk
    for (int v = 0; v < 7; v++) begin
      irq_in = '0;
      wait_cyc(6);
      reg_write('h018, {21'b0, VEC[v].mask});
      reg_read('h00C, rd);
      irq_in = VEC[v].pat;
      wait_cyc(6);
      check($sformatf("R2/R3/R4/R12 vec%0d valid", v), {31'b0, msg_valid}, {31'b0, VEC[v].exp != 0});
      if (VEC[v].exp != 0) begin
        check($sformatf("R8 vec%0d addr", v), msg_addr, T_ADR);
        check($sformatf("R8 vec%0d data", v), msg_data, T_DAT);
      end
      reg_read('h00C, rd);
      check($sformatf("R5 vec%0d pending", v), rd, {21'b0, VEC[v].exp});
      accept();
      check($sformatf("R12 vec%0d single write", v), {31'b0, msg_valid}, 0);
    end

    // R2 already-high input at unmask
    irq_in = '0;
    reg_write('h018, 0);
    wait_cyc(4);
    irq_in[2] = 1'b1;
    wait_cyc(6);
    reg_write('h018, 32'h004);
    wait_cyc(6);
    check("R2 unmask while high no write", {31'b0, msg_valid}, 0);
    reg_read('h00C, rd); check("R2 unmask while high no pending", rd, 0);
    irq_in[2] = 1'b0; wait_cyc(6);
    irq_in[2] = 1'b1; wait_cyc(6);
    check("R2 fresh edge writes", {31'b0, msg_valid}, 1);
    reg_read('h00C, rd); check("R2 fresh edge pending", rd, 32'h004);
    accept();

    // R9 / R6 / R7 / R10
    irq_in = '0;
    reg_write('h018, 32'h5FF);
    wait_cyc(6);
    reg_read('h00C, rd);
    irq_in[0] = 1'b1; wait_cyc(6);
    check("R9 first write", {31'b0, msg_valid}, 1);
    accept();
    irq_in[1] = 1'b1; wait_cyc(6);
    check("R9 no write before clear", {31'b0, msg_valid}, 0);
    reg_read('h01C, rd); check("R6 clear-only read value", rd, 32'h003);
    reg_read('h028, rd); check("R6 R7 level after clear", rd, 32'h003);
    reg_read('h01C, rd); check("R6 pending now empty", rd, 0);
    irq_in[2] = 1'b1; wait_cyc(6);
    check("R9 write after clear", {31'b0, msg_valid}, 1);
    wait_cyc(20);
    check("R10 still valid", {31'b0, msg_valid}, 1);
    reg_write('h004, 32'h1234_0007);
    wait_cyc(2);
    check("R10 held addr", msg_addr, T_ADR);
    check("R10 held data", msg_data, T_DAT);
    accept();
    check("R10 released", {31'b0, msg_valid}, 0);
    reg_write('h004, TGT);
    reg_read('h00C, rd);

    // R5 edge coinciding with clearing read
    irq_in = '0; wait_cyc(6);
    reg_read('h00C, rd);
    irq_in[0] = 1'b1; wait_cyc(6);
    accept();
    @(negedge clk);
    irq_in[1] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = AW'('h00C);
    @(negedge clk);
    reg_rd_en = 1'b0;
    check("R5 coincident read returns old", reg_rdata, 32'h001);
    wait_cyc(2);
    check("R5 coincident edge re-delivers", {31'b0, msg_valid}, 1);
    reg_read('h00C, rd); check("R5 coincident edge kept", rd, 32'h002);
    accept();

    // R11 capture disabled
    irq_in = '0; wait_cyc(6);
    reg_write('h024, 0);
    irq_in[3] = 1'b1; wait_cyc(6);
    check("R11 disabled no write", {31'b0, msg_valid}, 0);
    reg_read('h00C, rd); check("R11 disabled no pending", rd, 0);
    reg_write('h024, 1);

    // R7 / R4 live level
    irq_in = 11'h7FF; wait_cyc(4);
    reg_read('h028, rd); check("R7 R4 level all high", rd, 32'h5FF);
    reg_write('h018, 32'h7FF);
    reg_read('h018, rd); check("R4 mask bit9 reads 0", rd, 32'h5FF);

    finish_run();
  end
endmodule